// File: doc/BRIEF.md
# Ring Echo Transport Node

This block is the ring attachment of one node on a one-way packet ring. Each ring slot carries one 18-bit symbol. Every clock cycle, the node decides what to do with the symbol arriving on `ring_in`. It can forward the symbol, absorb it, or replace it. The result leaves on `ring_out` one cycle later. The node does not use credits. Reliability comes from echoes: a receiver turns each packet it is sent into an echo that goes on around the ring back to the sender. The echo says whether the packet was taken.

On the receive side, a packet addressed to this node is moved into a small local receive queue if the queue has room. The node then writes a positive echo into the freed slot. If the queue is full, the node writes a negative echo instead and leaves the queue as it was.

On the transmit side, the node writes a local packet only into a slot that is free. A slot is free when it arrives idle or when it carried an echo that this node has absorbed. The node keeps a copy of every packet it sends in an outgoing table of four entries. The entry index is the packet's tag. A positive echo releases the entry. A negative echo schedules the same packet to be sent again, without any action from the local side. An echo that matches no live entry is discarded, and the node raises a one-cycle flag.

Top module: `ringecho_node`

## Requirements
- R1: While `rst` is high, `ring_out` is all zero (idle), `rx_valid` and `echo_stray` are 0, and `tx_ready` is 0.
- R2: A symbol is laid out as follows. Bits [17:16] hold the kind (00 idle, 01 packet, 10 echo, 11 reserved). Bits [15:12] hold the target ID, bits [11:8] the source ID, bits [7:6] the tag and bits [5:0] the body. In an echo, the target is the original sender, the source is the echoing node, the tag is copied from the packet, and the body is 000001 for accept or 000000 for reject.
- R3: Any non-idle symbol that is neither a packet nor an echo addressed to this node appears unchanged on `ring_out` one cycle after it arrives on `ring_in`.
- R4: A packet addressed to this node, arriving while the receive queue holds fewer than 2 entries, is appended to the queue as (source, body). One cycle later its slot carries an accepting echo.
- R5: A packet addressed to this node, arriving while the receive queue is full, leaves the queue unchanged. One cycle later its slot carries a rejecting echo.
- R6: `tx_ready` is high only when all of these hold: the incoming slot is idle or is an echo addressed to this node, no resend is pending, and an outgoing entry is free. When `tx_valid` and `tx_ready` are both high, the next `ring_out` is a packet with source equal to this node, target `tx_dst`, body `tx_body`, and tag equal to the lowest free entry index.
- R7: At most 4 packets are outstanding. With 4 outstanding, `tx_ready` stays low.
- R8: An accepting echo whose tag names a live entry, and whose source equals that entry's target, frees the entry. The tag can then be reused.
- R9: A rejecting echo that matches a live entry marks that entry for resend. At the next free slot, the identical packet is sent again, ahead of any new local packet. The entry remains outstanding.
- R10: An echo addressed to this node whose tag names no live entry, or whose source differs from that entry's target, is dropped. `echo_stray` is then high for exactly the cycle in which the dropped echo's slot appears on `ring_out`.
- R11: An echo addressed to this node is never forwarded. If nothing is inserted, its slot leaves as idle.
- R12: The receive queue delivers entries in arrival order. `rx_valid`, `rx_src` and `rx_body` stay stable until `rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_in | input | 18 | Symbol arriving from the upstream neighbour |
| ring_out | output | 18 | Registered symbol sent to the downstream neighbour |
| tx_valid | input | 1 | Local packet offered for sending |
| tx_ready | output | 1 | Local packet is taken this cycle |
| tx_dst | input | 4 | Target ID of the local packet |
| tx_body | input | 6 | Body of the local packet |
| rx_valid | output | 1 | Receive queue head is valid |
| rx_ready | input | 1 | Consumer pops the head |
| rx_src | output | 4 | Source ID of the queue head |
| rx_body | output | 6 | Body of the queue head |
| echo_stray | output | 1 | Unmatched echo was dropped |

## Verification
The ring input is driven with a seeded random mix of symbols:
- idle slots;
- foreign packets, foreign echoes and reserved-kind symbols;
- packets addressed to this node;
- echoes addressed to this node, with matching tags, mismatched tags and wrong sources.

Local offers and consumer back-pressure are toggled at random throughout. Foreign traffic separates pass-through from absorption. Packets sent to this node while the consumer stalls separate accepting echoes from rejecting ones. Echo variants separate release, resend and stray drop. Directed sequences cover the remaining corners:
- filling all four outgoing entries;
- resend taking priority over a waiting local packet;
- reuse of a freed tag;
- a receive queue that overflows and then drains in order.

// File: rtl/ringecho_pkg.sv
package ringecho_pkg;

    localparam int SYM_W    = 18;
    localparam int KIND_W   = 2;
    localparam int ID_W     = 4;
    localparam int TAG_W    = 2;
    localparam int BODY_W   = SYM_W - KIND_W - 2 * ID_W - TAG_W;
    localparam int OB_DEPTH = 1 << TAG_W;

    typedef enum logic [KIND_W-1:0] {
        SK_IDLE = 2'b00,
        SK_PKT  = 2'b01,
        SK_ECHO = 2'b10,
        SK_RSVD = 2'b11
    } sym_kind_e;

    typedef struct packed {
        sym_kind_e          kind;
        logic [ID_W-1:0]    dst;
        logic [ID_W-1:0]    src;
        logic [TAG_W-1:0]   tag;
        logic [BODY_W-1:0]  body;
    } ring_sym_t;

    function automatic ring_sym_t make_pkt(input logic [ID_W-1:0] dst,
                                           input logic [ID_W-1:0] src,
                                           input logic [TAG_W-1:0] tag,
                                           input logic [BODY_W-1:0] body);
        ring_sym_t s;
        s.kind = SK_PKT;
        s.dst  = dst;
        s.src  = src;
        s.tag  = tag;
        s.body = body;
        return s;
    endfunction

    function automatic ring_sym_t make_echo(input logic [ID_W-1:0] dst,
                                            input logic [ID_W-1:0] src,
                                            input logic [TAG_W-1:0] tag,
                                            input logic accept);
        ring_sym_t s;
        s.kind = SK_ECHO;
        s.dst  = dst;
        s.src  = src;
        s.tag  = tag;
        s.body = BODY_W'(accept);
        return s;
    endfunction

    // Lowest set bit index; zero when the vector is empty.
    function automatic logic [TAG_W-1:0] lowest_set(input logic [OB_DEPTH-1:0] v);
        logic [TAG_W-1:0] idx;
        idx = '0;
        for (int i = OB_DEPTH - 1; i >= 0; i--) begin
            if (v[i]) idx = TAG_W'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/ringecho_outbuf.sv
module ringecho_outbuf
    import ringecho_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                alloc_en,
    input  logic [ID_W-1:0]     alloc_dst,
    input  logic [BODY_W-1:0]   alloc_body,
    input  logic                resend_en,
    input  logic                echo_en,
    input  logic [TAG_W-1:0]    echo_tag,
    input  logic [ID_W-1:0]     echo_src,
    input  logic                echo_ok,
    output logic                free_any,
    output logic [TAG_W-1:0]    free_idx,
    output logic                resend_any,
    output logic [TAG_W-1:0]    resend_idx,
    output logic [ID_W-1:0]     resend_dst,
    output logic [BODY_W-1:0]   resend_body,
    output logic                echo_hit,
    output logic [OB_DEPTH-1:0] valid_vec
);

    logic [OB_DEPTH-1:0] live;
    logic [OB_DEPTH-1:0] retry;
    logic [ID_W-1:0]     dst_arr  [OB_DEPTH];
    logic [BODY_W-1:0]   body_arr [OB_DEPTH];

    for (genvar i = 0; i < OB_DEPTH; i++) begin : g_entry
        logic              live_q;
        logic              retry_q;
        logic [ID_W-1:0]   dst_q;
        logic [BODY_W-1:0] body_q;
        logic              take_here;
        logic              echo_here;
        logic              resend_here;

        assign take_here   = alloc_en && (free_idx == TAG_W'(i));
        assign echo_here   = echo_en && echo_hit && (echo_tag == TAG_W'(i));
        assign resend_here = resend_en && (resend_idx == TAG_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                live_q  <= 1'b0;
                retry_q <= 1'b0;
            end else if (take_here) begin
                live_q  <= 1'b1;
                retry_q <= 1'b0;
            end else if (echo_here) begin
                live_q  <= !echo_ok;
                retry_q <= !echo_ok;
            end else if (resend_here) begin
                retry_q <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (take_here) begin
                dst_q  <= alloc_dst;
                body_q <= alloc_body;
            end
        end

        assign live[i]     = live_q;
        assign retry[i]    = retry_q;
        assign dst_arr[i]  = dst_q;
        assign body_arr[i] = body_q;
    end

    assign free_any    = !(&live);
    assign free_idx    = lowest_set(~live);
    assign resend_any  = |retry;
    assign resend_idx  = lowest_set(retry);
    assign resend_dst  = dst_arr[resend_idx];
    assign resend_body = body_arr[resend_idx];
    assign echo_hit    = live[echo_tag] && (dst_arr[echo_tag] == echo_src);
    assign valid_vec   = live;

endmodule

// File: rtl/ringecho_rxq.sv
module ringecho_rxq #(
    parameter int DEPTH = 2,
    parameter int W     = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         full,
    output logic         not_empty,
    output logic [W-1:0] head
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full      = (cnt_q == CW'(DEPTH));
    assign not_empty = (cnt_q != '0);
    assign head      = mem[rd_q];
    assign do_push   = push && !full;
    assign do_pop    = pop && not_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= step_ptr(wr_q);
            if (do_pop)  rd_q <= step_ptr(rd_q);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= push_data;
    end

endmodule

// File: rtl/ringecho_node.sv
module ringecho_node
    import ringecho_pkg::*;
#(
    parameter int NODE_ID   = 3,
    parameter int RXQ_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SYM_W-1:0]  ring_in,
    output logic [SYM_W-1:0]  ring_out,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [ID_W-1:0]   tx_dst,
    input  logic [BODY_W-1:0] tx_body,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [ID_W-1:0]   rx_src,
    output logic [BODY_W-1:0] rx_body,
    output logic              echo_stray
);

    localparam logic [ID_W-1:0] SELF = ID_W'(NODE_ID);
    localparam int RXW = ID_W + BODY_W;

    ring_sym_t           sym_in, sym_next;
    logic [SYM_W-1:0]    out_q;
    logic                stray_q;
    logic                for_me, pkt_me, echo_me, slot_open;
    logic                rx_full, rx_take;
    logic                resend_en, alloc_en;
    logic                free_any, resend_any, echo_hit;
    logic [TAG_W-1:0]    free_idx, resend_idx;
    logic [ID_W-1:0]     resend_dst;
    logic [BODY_W-1:0]   resend_body;
    logic [OB_DEPTH-1:0] ob_valid;
    logic [RXW-1:0]      rx_head;

    assign sym_in    = ring_sym_t'(ring_in);
    assign for_me    = (sym_in.dst == SELF);
    assign pkt_me    = (sym_in.kind == SK_PKT) && for_me;
    assign echo_me   = (sym_in.kind == SK_ECHO) && for_me;
    assign slot_open = (sym_in.kind == SK_IDLE) || echo_me;
    assign rx_take   = pkt_me && !rx_full;

    assign resend_en = !rst && slot_open && resend_any;
    assign tx_ready  = !rst && slot_open && !resend_any && free_any;
    assign alloc_en  = tx_valid && tx_ready;

    ringecho_outbuf u_outbuf (
        .clk         (clk),
        .rst         (rst),
        .alloc_en    (alloc_en),
        .alloc_dst   (tx_dst),
        .alloc_body  (tx_body),
        .resend_en   (resend_en),
        .echo_en     (echo_me && !rst),
        .echo_tag    (sym_in.tag),
        .echo_src    (sym_in.src),
        .echo_ok     (sym_in.body[0]),
        .free_any    (free_any),
        .free_idx    (free_idx),
        .resend_any  (resend_any),
        .resend_idx  (resend_idx),
        .resend_dst  (resend_dst),
        .resend_body (resend_body),
        .echo_hit    (echo_hit),
        .valid_vec   (ob_valid)
    );

    ringecho_rxq #(
        .DEPTH (RXQ_DEPTH),
        .W     (RXW)
    ) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .push      (rx_take && !rst),
        .push_data ({sym_in.src, sym_in.body}),
        .pop       (rx_ready),
        .full      (rx_full),
        .not_empty (rx_valid),
        .head      (rx_head)
    );

    assign rx_src  = rx_head[RXW-1 -: ID_W];
    assign rx_body = rx_head[BODY_W-1:0];

    always_comb begin
        if (pkt_me) begin
            sym_next = make_echo(sym_in.src, SELF, sym_in.tag, rx_take);
        end else if (resend_en) begin
            sym_next = make_pkt(resend_dst, SELF, resend_idx, resend_body);
        end else if (alloc_en) begin
            sym_next = make_pkt(tx_dst, SELF, free_idx, tx_body);
        end else if (slot_open) begin
            sym_next = '0;
        end else begin
            sym_next = sym_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= '0;
            stray_q <= 1'b0;
        end else begin
            out_q   <= sym_next;
            stray_q <= echo_me && !echo_hit;
        end
    end

    assign ring_out   = out_q;
    assign echo_stray = stray_q;

endmodule

// File: rtl/ringecho_node_chk.sv
module ringecho_node_chk
    import ringecho_pkg::*;
#(
    parameter int NODE_ID = 3
) (
    input logic                clk,
    input logic                rst,
    input logic [SYM_W-1:0]    ring_in,
    input logic [SYM_W-1:0]    ring_out,
    input logic                tx_valid,
    input logic                tx_ready,
    input logic [ID_W-1:0]     tx_dst,
    input logic                rx_valid,
    input logic                rx_ready,
    input logic [ID_W-1:0]     rx_src,
    input logic [BODY_W-1:0]   rx_body,
    input logic                echo_stray,
    input logic [OB_DEPTH-1:0] ob_valid
);

    localparam logic [ID_W-1:0] SELF = ID_W'(NODE_ID);

    ring_sym_t si, so;
    logic      in_mine;
    assign si      = ring_sym_t'(ring_in);
    assign so      = ring_sym_t'(ring_out);
    assign in_mine = (si.dst == SELF) && (si.kind == SK_PKT || si.kind == SK_ECHO);

    // R3: foreign traffic forwarded unchanged after one cycle
    p_pass_through_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(si.kind != SK_IDLE) && !$past(in_mine))
        |-> (ring_out == $past(ring_in)));

    // R4 and R5: a packet for this node becomes an echo back to its sender
    p_echo_replace_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(si.kind == SK_PKT && si.dst == SELF))
        |-> (so.kind == SK_ECHO && so.dst == $past(si.src) && so.tag == $past(si.tag)));

    // R6: ready only over a free slot
    p_ready_slot_r6: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> (si.kind == SK_IDLE || (si.kind == SK_ECHO && si.dst == SELF)));

    // R6: an accepted local packet is the next output symbol
    p_insert_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready)
        |=> (so.kind == SK_PKT && so.src == SELF && so.dst == $past(tx_dst)));

    // R7: no acceptance with the outgoing table full
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        ($countones(ob_valid) == OB_DEPTH) |-> !tx_ready);

    // R10: stray flag only for an absorbed echo
    p_stray_src_r10: assert property (@(posedge clk) disable iff (rst)
        echo_stray |-> ($past(!rst) && $past(si.kind == SK_ECHO && si.dst == SELF)));

    // R11: an echo for this node never appears as the same echo downstream
    p_echo_absorbed_r11: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(si.kind == SK_ECHO && si.dst == SELF))
        |-> !(so.kind == SK_ECHO));

    // R12: queue head held while not consumed
    p_rx_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_src) && $stable(rx_body)));

endmodule

bind ringecho_node ringecho_node_chk #(.NODE_ID(NODE_ID)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ring_in    (ring_in),
    .ring_out   (ring_out),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_dst     (tx_dst),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .rx_src     (rx_src),
    .rx_body    (rx_body),
    .echo_stray (echo_stray),
    .ob_valid   (ob_valid)
);

// File: tb/ringecho_node_tb.sv
`timescale 1ns/1ps
module ringecho_node_tb;
    import ringecho_pkg::*;

    localparam int ME  = 3;
    localparam int RXD = 2;

    logic              clk = 1'b0;
    logic              rst;
    logic [SYM_W-1:0]  ring_in;
    logic [SYM_W-1:0]  ring_out;
    logic              tx_valid;
    logic              tx_ready;
    logic [ID_W-1:0]   tx_dst;
    logic [BODY_W-1:0] tx_body;
    logic              rx_valid;
    logic              rx_ready;
    logic [ID_W-1:0]   rx_src;
    logic [BODY_W-1:0] rx_body;
    logic              echo_stray;

    always #2.5 clk = ~clk;

    ringecho_node #(.NODE_ID(ME), .RXQ_DEPTH(RXD)) u_dut (
        .clk(clk), .rst(rst), .ring_in(ring_in), .ring_out(ring_out),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_dst(tx_dst), .tx_body(tx_body),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_src(rx_src), .rx_body(rx_body),
        .echo_stray(echo_stray)
    );

    int checks = 0;
    int errors = 0;

    // reference model state
    bit               m_live  [OB_DEPTH];
    bit               m_retry [OB_DEPTH];
    logic [ID_W-1:0]  m_dst   [OB_DEPTH];
    logic [BODY_W-1:0] m_body [OB_DEPTH];
    logic [ID_W+BODY_W-1:0] m_q [$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [SYM_W-1:0] mk(input logic [1:0] k, input logic [3:0] d,
                                           input logic [3:0] s, input logic [1:0] t,
                                           input logic [5:0] b);
        return {k, d, s, t, b};
    endfunction

    function automatic int first_free();
        for (int i = 0; i < OB_DEPTH; i++) if (!m_live[i]) return i;
        return -1;
    endfunction

    function automatic int first_retry();
        for (int i = 0; i < OB_DEPTH; i++) if (m_retry[i]) return i;
        return -1;
    endfunction

    // Drive one slot at a negedge, predict, check at the next negedge.
    task automatic step(input logic [SYM_W-1:0] sym, input bit txv, input logic [3:0] td,
                        input logic [5:0] tb, input bit rr);
        logic [1:0] k;
        logic [3:0] sd, ss;
        logic [1:0] st;
        bit pkt_me, echo_me, open, ok, rdy, stray, push, pop;
        int fi, ri, t;
        logic [SYM_W-1:0] exp_out;
        string lbl;
        ring_in = sym; tx_valid = txv; tx_dst = td; tx_body = tb; rx_ready = rr;
        #1;
        k = sym[17:16]; sd = sym[15:12]; ss = sym[11:8]; st = sym[7:6];
        pkt_me  = (k == 2'b01) && (sd == 4'(ME));
        echo_me = (k == 2'b10) && (sd == 4'(ME));
        open    = (k == 2'b00) || echo_me;
        fi = first_free(); ri = first_retry();
        rdy = open && (ri < 0) && (fi >= 0);
        chk((fi < 0) ? "R7 tx_ready" : "R6 tx_ready", 32'(tx_ready), 32'(rdy));
        exp_out = '0; stray = 0; push = 0; ok = 0; lbl = "R6 idle";
        pop = (m_q.size() > 0) && rr;
        if (pkt_me) begin
            ok = (m_q.size() < RXD);
            push = ok;
            exp_out = mk(2'b10, ss, 4'(ME), st, ok ? 6'd1 : 6'd0);
            lbl = ok ? "R4 echo" : "R5 echo";
        end else if (echo_me) begin
            lbl = "R11 absorbed";
            t = int'(st);
            if (!(m_live[t] && m_dst[t] == ss)) begin
                stray = 1; lbl = "R10 stray";
            end
        end else if (k != 2'b00) begin
            exp_out = sym; lbl = "R3 pass";
        end
        if (open) begin
            if (ri >= 0) begin
                exp_out = mk(2'b01, m_dst[ri], 4'(ME), 2'(ri), m_body[ri]);
                m_retry[ri] = 0; lbl = "R9 resend";
            end else if (txv && rdy) begin
                exp_out = mk(2'b01, td, 4'(ME), 2'(fi), tb);
                m_live[fi] = 1; m_retry[fi] = 0; m_dst[fi] = td; m_body[fi] = tb;
                lbl = "R2/R6 insert";
            end
        end
        if (echo_me && !stray) begin
            t = int'(st);
            if (sym[0]) m_live[t] = 0;  // R8
            else m_retry[t] = 1;        // R9
        end
        if (pop) void'(m_q.pop_front());
        if (push) m_q.push_back({ss, sym[5:0]});
        @(posedge clk);
        @(negedge clk);
        chk(lbl, 32'(ring_out), 32'(exp_out));
        chk("R10 echo_stray", 32'(echo_stray), 32'(stray));
        chk("R12 rx_valid", 32'(rx_valid), 32'(m_q.size() > 0));
        if (m_q.size() > 0) chk("R12 rx head", 32'({rx_src, rx_body}), 32'(m_q[0]));
    endtask

    function automatic logic [3:0] foreign_id();
        return 4'((ME + 1 + $urandom % 15) % 16);
    endfunction

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; ring_in = '0; tx_valid = 0; tx_dst = '0; tx_body = '0; rx_ready = 0;
        for (int i = 0; i < OB_DEPTH; i++) begin m_live[i] = 0; m_retry[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 ring_out", 32'(ring_out), 32'd0);
        chk("R1 rx_valid", 32'(rx_valid), 32'd0);
        chk("R1 echo_stray", 32'(echo_stray), 32'd0);
        chk("R1 tx_ready", 32'(tx_ready), 32'd0);
        rst = 1'b0;

        // R6/R7: fill all four entries, then offer a fifth
        for (int i = 0; i < 4; i++) step('0, 1, 4'd5, 6'(8 + i), 1);
        step('0, 1, 4'd5, 6'd40, 1);
        // R8: positive echo frees tag 1, then tag 1 is reused
        step(mk(2'b10, 4'(ME), 4'd5, 2'd1, 6'd1), 0, 4'd0, 6'd0, 1);
        step('0, 1, 4'd6, 6'd33, 1);
        chk("R8 tag reuse", 32'(ring_out[7:6]), 32'd1);
        // R9: reject on tag 2, then resend beats a waiting local packet
        step(mk(2'b10, 4'(ME), 4'd5, 2'd2, 6'd0), 0, 4'd0, 6'd0, 1);
        step(mk(2'b10, 4'(ME), 4'd5, 2'd0, 6'd1), 1, 4'd7, 6'd21, 1);
        // R10: wrong source and free tag
        step(mk(2'b10, 4'(ME), 4'd9, 2'd1, 6'd1), 0, 4'd0, 6'd0, 1);
        step(mk(2'b10, 4'(ME), 4'd5, 2'd0, 6'd1), 0, 4'd0, 6'd0, 1);
        // R5/R12: overflow the receive queue, then drain in order
        step(mk(2'b01, 4'(ME), 4'd1, 2'd0, 6'd11), 0, 4'd0, 6'd0, 0);
        step(mk(2'b01, 4'(ME), 4'd2, 2'd1, 6'd12), 0, 4'd0, 6'd0, 0);
        step(mk(2'b01, 4'(ME), 4'd4, 2'd2, 6'd13), 0, 4'd0, 6'd0, 0);
        chk("R5 reject bit", 32'(ring_out[0]), 32'd0);
        for (int i = 0; i < 3; i++) step('0, 0, 4'd0, 6'd0, 1);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [SYM_W-1:0] s;
            int r, t;
            r = $urandom % 10;
            case (r)
                0, 1, 2: s = '0;
                3: s = mk(2'b01, foreign_id(), 4'($urandom), 2'($urandom), 6'($urandom));
                4: s = mk(2'b10, foreign_id(), 4'($urandom), 2'($urandom), 6'($urandom % 2));
                5, 6: s = mk(2'b01, 4'(ME), 4'($urandom), 2'($urandom), 6'($urandom));
                7, 8: begin
                    t = $urandom % OB_DEPTH;
                    s = mk(2'b10, 4'(ME),
                           (m_live[t] && ($urandom % 4 != 0)) ? m_dst[t] : 4'($urandom),
                           2'(t), ($urandom % 3 != 0) ? 6'd1 : 6'd0);
                end
                default: s = mk(2'b11, 4'($urandom), 4'($urandom), 2'($urandom), 6'($urandom));
            endcase
            step(s, bit'($urandom % 2), 4'($urandom), 6'($urandom), bit'($urandom % 4 != 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule